// File: doc/BRIEF.md
# Multi-Channel PCM Sample Fetch Engine

This block holds four independent playback channels and the byte-wide register window through which they are programmed. A channel, once started, reads signed 8-bit sample bytes from memory one at a time. Each read is a request/acknowledge handshake on a channel's own memory port. A period timer, advanced by an external tick enable, paces the reads. The latest byte is held as the channel's current value for a downstream mixer, together with the channel volume and a shared master volume.

Software first writes a channel index into the select register. Every per-channel offset of the 16-byte window then reaches that channel. Playback runs either once over `length+1` bytes or in a loop. In loop mode, every pass after the first restarts at a programmable offset into the sample. A channel that is not playing can have its current value written directly, so it can output a static level. Reads return the addressed byte one cycle after the address is presented.

Top module: `pcm_dma_channels`

## Requirements
- R1: Writing the select offset 0x0 with a value whose low two bits are k makes channel k the target of all per-channel offsets (0x2 to 0xE). Reading 0x0 returns k.
- R2: Writing 0xFF to offset 0x0 leaves the selected channel unchanged. Until the next select write, reading 0x0 returns the channel count, 4.
- R3: A control write (offset 0x7) with bit 7 set starts the channel. In the next cycle its request is high and its address equals the base. The base is offsets 0xC, 0xD and 0xE, holding bits 23:16, 15:8 and 7:0.
- R4: A started channel requests base+0, base+1, and so on. The length is offsets 0x8 (low byte) and 0x9 (high byte). The request and its address hold until acknowledged. The sample output takes the read byte in the cycle after the acknowledge.
- R5: Consecutive requests are separated by the period: offsets 0xA (low byte) and 0xB (high byte), counted in tick-enable cycles from the cycle the earlier request was raised. A period of 0 behaves as 1.
- R6: If the period has already elapsed when an acknowledge arrives late, the next request is raised in the cycle right after that acknowledge.
- R7: Without looping, the acknowledge of byte `length` ends playback. From the next cycle, control bit 7 reads 0, no request is made, and the sample output keeps the last byte.
- R8: With control bit 0 set, the byte after byte `length` is fetched from base plus the repeat offset. The repeat offset is offsets 0x4 (low byte) and 0x5 (high byte), and must be no larger than the length.
- R9: A control write with bit 7 clear stops the channel. In the next cycle the request is low and bit 7 reads 0. An acknowledge in the same cycle as that write is discarded.
- R10: Writing offset 0x2 while the channel is stopped sets its sample output in the next cycle. The same write while the channel is playing has no effect.
- R11: Offset 0x3 holds the largest magnitude (two's complement, so -128 gives 0x80) of every value loaded into the channel's sample. Writing it sets it directly.
- R12: Read data is registered: it reflects the offset presented one cycle earlier. The control offset reads bit 7 = playing, bits 6..1 = 1, and bit 0 = loop. Offset 0xF reads 0, and after reset all outputs are 0.
- R13: Offset 0x6 sets the channel's volume output, and offset 0x1 sets the shared master volume output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One pulse per sample-clock tick |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset within the window |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| mem_req | output | 4 | Per-channel fetch request |
| mem_addr | output | 96 | Per-channel 24-bit fetch address |
| mem_ack | input | 4 | Per-channel fetch acknowledge |
| mem_rdata | input | 32 | Per-channel fetched byte |
| sample_out | output | 32 | Per-channel current sample |
| volume_out | output | 32 | Per-channel volume |
| master_volume | output | 8 | Shared master volume |

## Verification
Two events can land on one channel in the same cycle: a software write to its control offset and a memory acknowledge. The bench provokes this on a looping channel by waiting for a cycle in which the responder raises acknowledge and placing the stop write in that same cycle. The result is judged in the following cycle, where the request must be low and the sample output must still hold the byte from before the discarded acknowledge. A behavioural reference model, compared on every clock, covers the same collision for restarts and peak writes.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FETCH = 2'd2
  } ch_state_t;

  // register window offsets
  localparam logic [3:0] A_SEL    = 4'h0;
  localparam logic [3:0] A_MVOL   = 4'h1;
  localparam logic [3:0] A_CUR    = 4'h2;
  localparam logic [3:0] A_PEAK   = 4'h3;
  localparam logic [3:0] A_ROF_L  = 4'h4;
  localparam logic [3:0] A_ROF_H  = 4'h5;
  localparam logic [3:0] A_VOL    = 4'h6;
  localparam logic [3:0] A_CTRL   = 4'h7;
  localparam logic [3:0] A_LEN_L  = 4'h8;
  localparam logic [3:0] A_LEN_H  = 4'h9;
  localparam logic [3:0] A_PER_L  = 4'hA;
  localparam logic [3:0] A_PER_H  = 4'hB;
  localparam logic [3:0] A_BASE_H = 4'hC;
  localparam logic [3:0] A_BASE_M = 4'hD;
  localparam logic [3:0] A_BASE_L = 4'hE;

  localparam int CTRL_GO_BIT   = 7;
  localparam int CTRL_LOOP_BIT = 0;

  function automatic logic [7:0] mag8(input logic [7:0] s);
    return s[7] ? (8'd0 - s) : s;
  endfunction

endpackage

// File: rtl/pcm_period_timer.sv
module pcm_period_timer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          load,
  input  logic          tick,
  input  logic [PW-1:0] period,
  output logic          expire
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (load)                cnt <= (period == '0) ? ONE : period;
    else if (!run)                cnt <= '0;
    else if (tick && cnt != '0)   cnt <= cnt - ONE;
  end

  // elapsed once the tick in this cycle brings the count to zero
  assign expire = (cnt == '0) || (cnt == ONE && tick);

  // R5
  load_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> cnt != '0);

endmodule

// File: rtl/pcm_dma_channel.sv
module pcm_dma_channel
  import pcm_pkg::*;
#(
  parameter int AW = 24,
  parameter int LW = 16,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [3:0]    addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rd_byte,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [7:0]    mem_rdata,
  output logic [7:0]    sample,
  output logic [7:0]    volume
);
  ch_state_t     state;
  logic [AW-1:0] base;
  logic [PW-1:0] per;
  logic [LW-1:0] len, rof, offs, nxt_offs;
  logic [7:0]    cur, peak, vol;
  logic          loop_en;

  logic ctl_wr, go, halt, got, last_byte, finish, tmr_exp, tmr_load, act;
  logic cur_wr, peak_wr;

  assign act       = (state != ST_IDLE);
  assign ctl_wr    = wr_en && (addr == A_CTRL);
  assign go        = ctl_wr &&  wdata[CTRL_GO_BIT];
  assign halt      = ctl_wr && !wdata[CTRL_GO_BIT];
  assign got       = (state == ST_FETCH) && mem_ack;
  assign last_byte = (offs == len);
  assign finish    = got && last_byte && !loop_en;
  assign nxt_offs  = last_byte ? rof : offs + LW'(1);
  assign cur_wr    = wr_en && (addr == A_CUR) && (state == ST_IDLE);
  assign peak_wr   = wr_en && (addr == A_PEAK);

  assign tmr_load = go ||
                    (!ctl_wr && ((got && !finish && tmr_exp) ||
                                 ((state == ST_WAIT) && tmr_exp)));

  pcm_period_timer #(.PW(PW)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .run    (act),
    .load   (tmr_load),
    .tick   (tick),
    .period (per),
    .expire (tmr_exp)
  );

  // fetch sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      offs     <= '0;
      mem_addr <= '0;
    end else if (go) begin
      state    <= ST_FETCH;
      offs     <= '0;
      mem_addr <= base;
    end else if (halt) begin
      state    <= ST_IDLE;
    end else if (got) begin
      if (finish) begin
        state <= ST_IDLE;
      end else begin
        offs <= nxt_offs;
        if (tmr_exp) begin
          state    <= ST_FETCH;
          mem_addr <= base + AW'(nxt_offs);
        end else begin
          state    <= ST_WAIT;
        end
      end
    end else if (state == ST_WAIT && tmr_exp) begin
      state    <= ST_FETCH;
      mem_addr <= base + AW'(offs);
    end
  end

  // configuration bytes
  always_ff @(posedge clk) begin
    if (rst) begin
      base    <= '0;
      per     <= '0;
      len     <= '0;
      rof     <= '0;
      vol     <= '0;
      loop_en <= 1'b0;
    end else if (wr_en) begin
      unique case (addr)
        A_ROF_L:  rof[7:0]       <= wdata;
        A_ROF_H:  rof[LW-1:8]    <= wdata[LW-9:0];
        A_VOL:    vol            <= wdata;
        A_CTRL:   loop_en        <= wdata[CTRL_LOOP_BIT];
        A_LEN_L:  len[7:0]       <= wdata;
        A_LEN_H:  len[LW-1:8]    <= wdata[LW-9:0];
        A_PER_L:  per[7:0]       <= wdata;
        A_PER_H:  per[PW-1:8]    <= wdata[PW-9:0];
        A_BASE_H: base[AW-1:16]  <= wdata[AW-17:0];
        A_BASE_M: base[15:8]     <= wdata;
        A_BASE_L: base[7:0]      <= wdata;
        default: ;
      endcase
    end
  end

  // current sample and peak magnitude
  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= '0;
      peak <= '0;
    end else begin
      if (got && !ctl_wr) begin
        cur <= mem_rdata;
        if (mag8(mem_rdata) > peak) peak <= mag8(mem_rdata);
      end else if (cur_wr) begin
        cur <= wdata;
        if (mag8(wdata) > peak) peak <= mag8(wdata);
      end
      if (peak_wr) peak <= wdata;
    end
  end

  always_comb begin
    unique case (addr)
      A_CUR:    rd_byte = cur;
      A_PEAK:   rd_byte = peak;
      A_ROF_L:  rd_byte = rof[7:0];
      A_ROF_H:  rd_byte = 8'(rof[LW-1:8]);
      A_VOL:    rd_byte = vol;
      A_CTRL:   rd_byte = {act, 6'h3F, loop_en};
      A_LEN_L:  rd_byte = len[7:0];
      A_LEN_H:  rd_byte = 8'(len[LW-1:8]);
      A_PER_L:  rd_byte = per[7:0];
      A_PER_H:  rd_byte = 8'(per[PW-1:8]);
      A_BASE_H: rd_byte = 8'(base[AW-1:16]);
      A_BASE_M: rd_byte = base[15:8];
      A_BASE_L: rd_byte = base[7:0];
      default:  rd_byte = 8'h00;
    endcase
  end

  assign mem_req = (state == ST_FETCH);
  assign sample  = cur;
  assign volume  = vol;

  // R3
  start_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    go |=> mem_req && mem_addr == $past(base));
  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    halt |=> !mem_req && !act);
  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack && !ctl_wr |=> mem_req && $stable(mem_addr));
  // R10
  static_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    act && wr_en && addr == A_CUR && !got |=> $stable(sample));
  // R7
  one_shot_end_chk: assert property (@(posedge clk) disable iff (rst)
    finish && !ctl_wr |=> !mem_req && !act && sample == $past(mem_rdata));

endmodule

// File: rtl/pcm_reg_decode.sv
module pcm_reg_decode
  import pcm_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic [3:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  input  logic [NCH*8-1:0] ch_rd,
  output logic [NCH-1:0]   ch_wr,
  output logic [7:0]       master_vol,
  output logic [7:0]       reg_rdata
);
  localparam int SELW = $clog2(NCH);

  logic [SELW-1:0] sel;
  logic            probe;
  logic [7:0]      sel_rd;
  logic            sel_wr;

  assign sel_wr = reg_wr && (reg_addr == A_SEL);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel        <= '0;
      probe      <= 1'b0;
      master_vol <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_SEL) begin
        if (reg_wdata == 8'hFF) begin
          probe <= 1'b1;
        end else begin
          probe <= 1'b0;
          sel   <= reg_wdata[SELW-1:0];
        end
      end
      if (reg_addr == A_MVOL) master_vol <= reg_wdata;
    end
  end

  genvar i;
  generate
    for (i = 0; i < NCH; i++) begin : g_wr
      assign ch_wr[i] = reg_wr && (sel == SELW'(i));
    end
  endgenerate

  assign sel_rd = ch_rd[{sel, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr)
        A_SEL:   reg_rdata <= probe ? 8'(NCH) : 8'(sel);
        A_MVOL:  reg_rdata <= master_vol;
        default: reg_rdata <= sel_rd;
      endcase
    end
  end

  // R2
  probe_keep_chk: assert property (@(posedge clk) disable iff (rst)
    sel_wr && reg_wdata == 8'hFF |=> $stable(sel) && probe);
  // R1
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_wr));

endmodule

// File: rtl/pcm_dma_channels.sv
module pcm_dma_channels
  import pcm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 24,
  parameter int LW  = 16,
  parameter int PW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [NCH-1:0]    mem_req,
  output logic [NCH*AW-1:0] mem_addr,
  input  logic [NCH-1:0]    mem_ack,
  input  logic [NCH*8-1:0]  mem_rdata,
  output logic [NCH*8-1:0]  sample_out,
  output logic [NCH*8-1:0]  volume_out,
  output logic [7:0]        master_volume
);
  logic [NCH-1:0]   ch_wr;
  logic [NCH*8-1:0] ch_rd;

  pcm_reg_decode #(.NCH(NCH)) u_dec (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .ch_rd      (ch_rd),
    .ch_wr      (ch_wr),
    .master_vol (master_volume),
    .reg_rdata  (reg_rdata)
  );

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      pcm_dma_channel #(.AW(AW), .LW(LW), .PW(PW)) u_ch (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_en),
        .wr_en     (ch_wr[c]),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rd_byte   (ch_rd[c*8 +: 8]),
        .mem_req   (mem_req[c]),
        .mem_addr  (mem_addr[c*AW +: AW]),
        .mem_ack   (mem_ack[c]),
        .mem_rdata (mem_rdata[c*8 +: 8]),
        .sample    (sample_out[c*8 +: 8]),
        .volume    (volume_out[c*8 +: 8])
      );
    end
  endgenerate

endmodule

// File: tb/pcm_dma_channels_test.sv
module pcm_dma_channels_test;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_en = 1'b1;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = 4'h0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic [NCH-1:0] mem_req;
  logic [NCH*24-1:0] mem_addr;
  logic [NCH-1:0] mem_ack = '0;
  logic [NCH*8-1:0] mem_rdata = '0;
  logic [NCH*8-1:0] sample_out, volume_out;
  logic [7:0] master_volume;

  pcm_dma_channels uut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .sample_out(sample_out),
    .volume_out(volume_out), .master_volume(master_volume));

  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0, cyc = 0;
  int lat[NCH];
  int rcnt[NCH];
  int tick_div = 1, tick_ph = 0;

  // reference model state
  int m_st[NCH], m_tk[NCH], m_pl[NCH], m_offs[NCH], m_addr[NCH];
  int m_cur[NCH], m_peak[NCH], m_base[NCH], m_per[NCH], m_len[NCH];
  int m_rof[NCH], m_vol[NCH], m_rpt[NCH];
  int m_sel = 0, m_probe = 0, m_mvol = 0, e_rdata = 0;

  function automatic int memf(int a);
    return ((a & 255) * 37 + ((a >> 8) & 255) * 11 + ((a >> 16) & 255) + 3) & 255;
  endfunction

  function automatic int magm(int s);
    return (s >= 128) ? 256 - s : s;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int mread(int a);
    int c = m_sel;
    case (a)
      0: return m_probe ? NCH : m_sel;
      1: return m_mvol;
      2: return m_cur[c];
      3: return m_peak[c];
      4: return m_rof[c] & 255;
      5: return (m_rof[c] >> 8) & 255;
      6: return m_vol[c];
      7: return ((m_st[c] != 0) ? 128 : 0) | 126 | m_rpt[c];
      8: return m_len[c] & 255;
      9: return (m_len[c] >> 8) & 255;
      10: return m_per[c] & 255;
      11: return (m_per[c] >> 8) & 255;
      12: return (m_base[c] >> 16) & 255;
      13: return (m_base[c] >> 8) & 255;
      14: return m_base[c] & 255;
      default: return 0;
    endcase
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_st[c] = 0; m_tk[c] = 0; m_pl[c] = 1; m_offs[c] = 0; m_addr[c] = 0;
        m_cur[c] = 0; m_peak[c] = 0; m_base[c] = 0; m_per[c] = 0; m_len[c] = 0;
        m_rof[c] = 0; m_vol[c] = 0; m_rpt[c] = 0;
      end
      m_sel = 0; m_probe = 0; m_mvol = 0; e_rdata = 0;
    end else begin
      int rd_next;
      rd_next = mread(int'(reg_addr));
      for (int c = 0; c < NCH; c++) begin
        bit wrc, ctl, got, exp_now;
        int a, d, tk, old_st, no;
        wrc = reg_wr && (m_sel == c);
        a = int'(reg_addr); d = int'(reg_wdata); tk = int'(tick_en);
        old_st = m_st[c];
        ctl = wrc && a == 7;
        got = (m_st[c] == 2) && mem_ack[c];
        exp_now = (m_tk[c] + tk) >= m_pl[c];
        if (ctl) begin
          m_rpt[c] = d & 1;
          if (d >= 128) begin
            m_st[c] = 2; m_offs[c] = 0; m_addr[c] = m_base[c];
            m_pl[c] = (m_per[c] == 0) ? 1 : m_per[c]; m_tk[c] = 0;
          end else m_st[c] = 0;
        end else if (got) begin
          m_cur[c] = memf(m_addr[c]);
          if (magm(m_cur[c]) > m_peak[c]) m_peak[c] = magm(m_cur[c]);
          if (m_offs[c] == m_len[c] && m_rpt[c] == 0) m_st[c] = 0;
          else begin
            no = (m_offs[c] == m_len[c]) ? m_rof[c] : ((m_offs[c] + 1) & 16'hFFFF);
            m_offs[c] = no;
            if (exp_now) begin
              m_st[c] = 2; m_addr[c] = (m_base[c] + no) & 24'hFFFFFF;
              m_pl[c] = (m_per[c] == 0) ? 1 : m_per[c]; m_tk[c] = 0;
            end else begin
              m_st[c] = 1; m_tk[c] = m_tk[c] + tk;
            end
          end
        end else if (m_st[c] == 1 && exp_now) begin
          m_st[c] = 2; m_addr[c] = (m_base[c] + m_offs[c]) & 24'hFFFFFF;
          m_pl[c] = (m_per[c] == 0) ? 1 : m_per[c]; m_tk[c] = 0;
        end else if (m_st[c] != 0) m_tk[c] = m_tk[c] + tk;
        if (wrc) begin
          case (a)
            2: if (old_st == 0) begin
                 m_cur[c] = d;
                 if (magm(d) > m_peak[c]) m_peak[c] = magm(d);
               end
            3: m_peak[c] = d;
            4: m_rof[c] = (m_rof[c] & 16'hFF00) | d;
            5: m_rof[c] = (m_rof[c] & 255) | (d << 8);
            6: m_vol[c] = d;
            8: m_len[c] = (m_len[c] & 16'hFF00) | d;
            9: m_len[c] = (m_len[c] & 255) | (d << 8);
            10: m_per[c] = (m_per[c] & 16'hFF00) | d;
            11: m_per[c] = (m_per[c] & 255) | (d << 8);
            12: m_base[c] = (m_base[c] & 24'h00FFFF) | (d << 16);
            13: m_base[c] = (m_base[c] & 24'hFF00FF) | (d << 8);
            14: m_base[c] = (m_base[c] & 24'hFFFF00) | d;
            default: ;
          endcase
        end
      end
      if (reg_wr && reg_addr == 4'h0) begin
        if (reg_wdata == 8'hFF) m_probe = 1;
        else begin m_probe = 0; m_sel = int'(reg_wdata) & 3; end
      end
      if (reg_wr && reg_addr == 4'h1) m_mvol = int'(reg_wdata);
      e_rdata = rd_next;
    end
  end

  // per-clock comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < NCH; c++) begin
        check("R5 R6 request", int'(mem_req[c]), (m_st[c] == 2) ? 1 : 0);
        if (mem_req[c]) check("R4 address", int'(mem_addr[c*24 +: 24]), m_addr[c]);
        check("R4 sample", int'(sample_out[c*8 +: 8]), m_cur[c]);
        check("R13 volume", int'(volume_out[c*8 +: 8]), m_vol[c]);
      end
      check("R13 master", int'(master_volume), m_mvol);
      check("R12 read data", int'(reg_rdata), e_rdata);
    end
  end

  // memory responder and tick generator
  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      int cn;
      mem_rdata[c*8 +: 8] <= 8'(memf(int'(mem_addr[c*24 +: 24])));
      if (!mem_req[c]) begin
        mem_ack[c] <= 1'b0; rcnt[c] = 0;
      end else begin
        cn = mem_ack[c] ? 1 : rcnt[c] + 1;
        if (cn >= lat[c]) begin mem_ack[c] <= 1'b1; rcnt[c] = 0; end
        else begin mem_ack[c] <= 1'b0; rcnt[c] = cn; end
      end
    end
    tick_ph = (tick_ph + 1) % tick_div;
    tick_en <= (tick_div <= 1) ? 1'b1 : (tick_ph == 0);
  end

  // gap monitors
  bit mon1 = 0, mon2 = 0, wrapped = 0, req2_prev = 0;
  int last_ack1 = -1, prev_a1 = -1, ticks = 0, tick_mark = -1;
  always @(posedge clk) begin
    if (mon1 && mem_ack[1]) begin
      // R6: period 1 already elapsed, so acks are latency cycles apart
      if (last_ack1 >= 0) check("R6 ack spacing", cyc - last_ack1, 3);
      last_ack1 = cyc;
      if (prev_a1 == 24'h0000F2 && int'(mem_addr[47:24]) == 24'h0000F1) wrapped = 1;
      prev_a1 = int'(mem_addr[47:24]);
    end
    if (mon2 && mem_req[2] && !req2_prev) begin
      if (tick_mark >= 0) check("R5 tick gap", ticks - tick_mark, 2);
      tick_mark = ticks;
    end
    req2_prev = mem_req[2];
    ticks = ticks + int'(tick_en);
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
    @(negedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(int a, int exp, string tag);
    @(negedge clk); #1;
    reg_addr = 4'(a);
    @(negedge clk); #1;
    check(tag, int'(reg_rdata), exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : stim
    int held;
    for (int c = 0; c < NCH; c++) begin lat[c] = 1; rcnt[c] = 0; end
    idle(3);
    rst = 1'b0;
    idle(1);
    // R12 reset state
    check("R12 reset request", int'(mem_req), 0);
    check("R12 reset sample", int'(sample_out), 0);
    check("R12 reset read", int'(reg_rdata), 0);

    // channel 0: one-shot, period 4, four bytes
    wr(0, 0); wr(1, 8'hFF);
    wr(12, 8'h01); wr(13, 8'h23); wr(14, 8'h40);
    wr(10, 4); wr(11, 0); wr(8, 3); wr(9, 0); wr(6, 8'h80);
    wr(7, 8'h80);
    check("R3 request after start", int'(mem_req[0]), 1);
    check("R3 first address", int'(mem_addr[23:0]), 24'h012340);
    idle(30);
    rd(7, 8'h7E, "R7 control after one-shot");
    check("R7 last byte held", int'(sample_out[7:0]), memf(24'h012343));
    check("R13 channel volume", int'(volume_out[7:0]), 8'h80);
    rd(15, 0, "R12 unused offset");

    // R2 probe, then R1 selection
    wr(0, 8'hFF);
    rd(0, NCH, "R2 probe count");
    rd(6, 8'h80, "R2 selection kept");
    wr(0, 1);
    rd(0, 1, "R1 select readback");
    rd(6, 0, "R1 other channel");

    // channel 1: loop with repeat offset 1, period 0, late acks
    lat[1] = 3;
    wr(12, 0); wr(13, 0); wr(14, 8'hF0);
    wr(10, 0); wr(11, 0); wr(8, 2); wr(9, 0); wr(4, 1); wr(5, 0);
    wr(7, 8'h81);
    idle(4);
    mon1 = 1;
    idle(30);
    mon1 = 0;
    check("R8 loop resumes at repeat offset", int'(wrapped), 1);
    // R9: stop written in an acknowledge cycle
    do begin @(negedge clk); #1; end while (mem_ack[1] !== 1'b1);
    held = int'(sample_out[15:8]);
    reg_wr = 1'b1; reg_addr = 4'h7; reg_wdata = 8'h00;
    @(negedge clk); #1;
    reg_wr = 1'b0;
    check("R9 request dropped", int'(mem_req[1]), 0);
    check("R9 ack discarded", int'(sample_out[15:8]), held);
    rd(7, 8'h7E, "R9 control after stop");

    // R10 and R11 on the stopped channel 1
    wr(3, 0);
    wr(2, 8'h9C);
    check("R10 static value", int'(sample_out[15:8]), 8'h9C);
    rd(3, 8'h64, "R11 peak of 0x9C");
    wr(2, 8'h80);
    rd(3, 8'h80, "R11 peak of 0x80");
    wr(2, 8'h05);
    rd(3, 8'h80, "R11 peak kept");

    // R10 ignored while playing on channel 0
    wr(0, 0);
    wr(10, 60); wr(7, 8'h81);
    idle(5);
    held = int'(sample_out[7:0]);
    wr(2, 8'h11);
    check("R10 write ignored while playing", int'(sample_out[7:0]), held);
    wr(7, 0);
    wr(2, 8'h11);
    check("R10 write after stop", int'(sample_out[7:0]), 8'h11);

    // channel 2: slow ticks, period 2, two bytes
    tick_div = 3;
    wr(0, 2);
    wr(12, 8'h10); wr(13, 0); wr(14, 0);
    wr(10, 2); wr(11, 0); wr(8, 1); wr(9, 0); wr(6, 8'h40);
    mon2 = 1;
    wr(7, 8'h80);
    idle(40);
    mon2 = 0;
    rd(7, 8'h7E, "R7 slow channel finished");
    check("R13 volume channel 2", int'(volume_out[23:16]), 8'h40);
    check("R1 untouched channel", int'(sample_out[31:24]), 0);
    idle(4);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule